// File: doc/BRIEF.md
# Opcode-Menu Software SPI Sequencer

This block issues SPI flash commands whose opcodes come from a small table that software fills and then freezes. Eight 8-bit opcodes sit in two 32-bit menu words and two 8-bit prefix opcodes sit in a prefix word. Software starts a cycle by writing a control word. That word names an entry of the table, tells whether data bytes follow the opcode, and may ask for a prefix opcode to go out first. A write-enable command is a typical prefix. The prefix and the main command then form one uninterrupted sequence.

The sequencer shares the SPI pins with a hardware sequencer. Before it drives chip select it raises a bus request and waits for the grant. It drops the request in the same cycle that its last frame ends. Data bytes move through a byte buffer that the block shares with the hardware sequencer. Each outgoing byte is read from the buffer, and the byte received in the same slot is written back to that slot.

Top module: `opmenu_spi_seq`

## Requirements
- R1: Menu index i selects byte i (bits [8i+7:8i]) of the low menu word (address 2) for i < 4, and byte i-4 of the high menu word (address 3) for i >= 4. The selected opcode is sent most significant bit first.
- R2: The prefix word (address 1) holds prefix 0 in bits [7:0] and prefix 1 in bits [15:8]. With control bit 10 set, the prefix chosen by control bit 11 goes out as its own chip-select frame. Chip select is then high for exactly one clock, and the main frame follows.
- R3: The control word (address 0) keeps and reads back the fields last written while idle: index in bits [14:12], byte count in bits [21:16], data enable in bit 22, prefix request in bit 10 and prefix select in bit 11. Bit 9 starts a cycle and always reads 0.
- R4: Control bit 0 reads 1 while a cycle is in progress. Bit 2 (done), bit 3 (cycle error) and bit 4 (access error) are cleared by writing 1 to them. Done is set in the clock in which busy falls, and that set wins over a clear written in the same clock.
- R5: A pulse on lock_set sets a sticky lock flag, which reads back in control bit 15. Once the flag is set, writes to the prefix and menu words are ignored.
- R6: A start written before lock-down is refused. The access error flag is set and no bus request is raised.
- R7: Each bit takes two clocks in SPI mode 0: one with SCK low and one with SCK high, with MOSI held for both. With bit 22 clear only the opcode byte is sent, and the same holds when the count is 0. With bit 22 set, data bytes k = 0..count-1 are sent from buffer slot k, and the byte received during data byte k is written to slot k in that byte's last clock.
- R8: A start written while busy is ignored and sets the cycle error flag. Field writes made while busy are ignored as well.
- R9: bus_req is high from the clock after an accepted start until the last frame ends. Chip select falls only after bus_gnt has been seen high.
- R10: After reset all control and status fields and both table words read 0, chip select is high and bus_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 prefix, 2 low menu, 3 high menu |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| lock_set | input | 1 | Pulse that freezes the table |
| bus_req | output | 1 | Request for the shared SPI pins |
| bus_gnt | input | 1 | Grant of the shared SPI pins |
| buf_raddr | output | BUF_AW | Buffer slot of the next byte to send |
| buf_rdata | input | 8 | Buffer byte at buf_raddr |
| buf_we | output | 1 | Buffer write strobe for a received byte |
| buf_waddr | output | BUF_AW | Buffer slot being written |
| buf_wdata | output | 8 | Received byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that the arbiter keeps bus_gnt high for as long as bus_req is high after granting. Without that, the check that chip select falls only after a grant would also have to cover the gap between prefix and main frame. The bench raises the grant after a chosen delay, holds it until busy has fallen, and only then lowers it. It also changes spi_miso and the buffer contents only just after a rising edge, so that the received byte is stable across the clock in which it is written back.

// File: rtl/opmenu_spi_pkg.sv
package opmenu_spi_pkg;
    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_SHIFT, SQ_GAP} sq_state_e;

    localparam logic [1:0] A_CTL     = 2'd0;
    localparam logic [1:0] A_PFX     = 2'd1;
    localparam logic [1:0] A_MENU_LO = 2'd2;
    localparam logic [1:0] A_MENU_HI = 2'd3;

    localparam int B_BUSY = 0;
    localparam int B_DONE = 2;
    localparam int B_CERR = 3;
    localparam int B_AERR = 4;
    localparam int B_GO   = 9;
    localparam int B_ATOM = 10;
    localparam int B_PSEL = 11;
    localparam int B_IDX  = 12;
    localparam int B_LOCK = 15;
    localparam int B_CNT  = 16;
    localparam int B_DS   = 22;

    localparam int OP_W     = 8;
    localparam int MENU_N   = 8;
    localparam int MENU_IW  = $clog2(MENU_N);
    localparam int MENU_HALF = MENU_N / 2;
endpackage

// File: rtl/opmenu_spi_table.sv
module opmenu_spi_table
    import opmenu_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wr_data,
    input  logic               lock_set,
    input  logic [MENU_IW-1:0] main_idx,
    input  logic               pfx_sel,
    output logic [OP_W-1:0]    main_op,
    output logic [OP_W-1:0]    pfx_op,
    output logic               locked,
    output logic [31:0]        rd_data
);
    typedef struct packed {
        logic [MENU_N-1:0][OP_W-1:0] menu;
        logic [1:0][OP_W-1:0]        pfx;
        logic                        locked;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && !tbl_q.locked) begin
            case (addr)
                A_PFX:     tbl_d.pfx = wr_data[2*OP_W-1:0];
                A_MENU_LO: tbl_d.menu[MENU_HALF-1:0] = wr_data;
                A_MENU_HI: tbl_d.menu[MENU_N-1:MENU_HALF] = wr_data;
                default: ;
            endcase
        end
        if (lock_set) tbl_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign main_op = tbl_q.menu[main_idx];
    assign pfx_op  = tbl_q.pfx[pfx_sel];
    assign locked  = tbl_q.locked;

    always_comb begin
        case (addr)
            A_PFX:     rd_data = {{(32-2*OP_W){1'b0}}, tbl_q.pfx};
            A_MENU_LO: rd_data = tbl_q.menu[MENU_HALF-1:0];
            A_MENU_HI: rd_data = tbl_q.menu[MENU_N-1:MENU_HALF];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/opmenu_spi_engine.sv
module opmenu_spi_engine
    import opmenu_spi_pkg::*;
#(
    parameter int BUF_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wr_data,
    input  logic               locked,
    input  logic [OP_W-1:0]    main_op,
    input  logic [OP_W-1:0]    pfx_op,
    output logic [MENU_IW-1:0] main_idx,
    output logic               pfx_sel,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [BUF_AW-1:0]  buf_raddr,
    input  logic [OP_W-1:0]    buf_rdata,
    output logic               buf_we,
    output logic [BUF_AW-1:0]  buf_waddr,
    output logic [OP_W-1:0]    buf_wdata,
    output logic               spi_cs_n,
    output logic               spi_sck,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [31:0]        ctl_word
);
    localparam int BIT_W = $clog2(OP_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OP_W - 1);

    typedef struct packed {
        sq_state_e          st;
        logic               atom;
        logic               psel;
        logic [MENU_IW-1:0] idx;
        logic               ds;
        logic [BUF_AW-1:0]  cnt;
        logic               done;
        logic               cerr;
        logic               aerr;
        logic               ph;
        logic [BIT_W-1:0]   bitn;
        logic               pre;
        logic [BUF_AW-1:0]  dcnt;
        logic [OP_W-1:0]    tx;
        logic [OP_W-1:0]    rx;
    } eng_t;

    eng_t eng_d, eng_q;
    logic busy, ctl_wr, go;

    assign busy   = (eng_q.st != SQ_IDLE);
    assign ctl_wr = wr_en && (addr == A_CTL);
    assign go     = ctl_wr && wr_data[B_GO];

    always_comb begin
        eng_d  = eng_q;
        buf_we = 1'b0;
        if (ctl_wr) begin
            if (wr_data[B_DONE]) eng_d.done = 1'b0;
            if (wr_data[B_CERR]) eng_d.cerr = 1'b0;
            if (wr_data[B_AERR]) eng_d.aerr = 1'b0;
        end
        case (eng_q.st)
            SQ_WAIT: if (bus_gnt) begin
                eng_d.st   = SQ_SHIFT;
                eng_d.tx   = eng_q.atom ? pfx_op : main_op;
                eng_d.pre  = eng_q.atom;
                eng_d.ph   = 1'b0;
                eng_d.bitn = '0;
                eng_d.dcnt = '0;
            end
            SQ_GAP: begin
                eng_d.st  = SQ_SHIFT;
                eng_d.tx  = main_op;
                eng_d.pre = 1'b0;
            end
            SQ_SHIFT: begin
                eng_d.ph = !eng_q.ph;
                if (eng_q.ph) begin
                    eng_d.rx = {eng_q.rx[OP_W-2:0], spi_miso};
                    if (eng_q.bitn != LAST_BIT) begin
                        eng_d.bitn = eng_q.bitn + 1'b1;
                        eng_d.tx   = {eng_q.tx[OP_W-2:0], 1'b0};
                    end else begin
                        eng_d.bitn = '0;
                        if (eng_q.pre) begin
                            eng_d.st = SQ_GAP;
                        end else if (eng_q.dcnt == '0) begin
                            if (eng_q.ds && eng_q.cnt != '0) begin
                                eng_d.tx   = buf_rdata;
                                eng_d.dcnt = BUF_AW'(1);
                            end else begin
                                eng_d.st   = SQ_IDLE;
                                eng_d.done = 1'b1;
                            end
                        end else begin
                            buf_we = 1'b1;
                            if (eng_q.dcnt != eng_q.cnt) begin
                                eng_d.tx   = buf_rdata;
                                eng_d.dcnt = eng_q.dcnt + 1'b1;
                            end else begin
                                eng_d.st   = SQ_IDLE;
                                eng_d.done = 1'b1;
                            end
                        end
                    end
                end
            end
            default: ;
        endcase
        if (ctl_wr) begin
            if (busy) begin
                if (go) eng_d.cerr = 1'b1;
            end else begin
                eng_d.atom = wr_data[B_ATOM];
                eng_d.psel = wr_data[B_PSEL];
                eng_d.idx  = wr_data[B_IDX +: MENU_IW];
                eng_d.ds   = wr_data[B_DS];
                eng_d.cnt  = wr_data[B_CNT +: BUF_AW];
                if (go) begin
                    if (!locked) eng_d.aerr = 1'b1;
                    else         eng_d.st   = SQ_WAIT;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign main_idx  = eng_q.idx;
    assign pfx_sel   = eng_q.psel;
    assign bus_req   = busy;
    assign spi_cs_n  = (eng_q.st != SQ_SHIFT);
    assign spi_sck   = (eng_q.st == SQ_SHIFT) && eng_q.ph;
    assign spi_mosi  = (eng_q.st == SQ_SHIFT) && eng_q.tx[OP_W-1];
    assign buf_raddr = eng_q.dcnt;
    assign buf_waddr = eng_q.dcnt - 1'b1;
    assign buf_wdata = {eng_q.rx[OP_W-2:0], spi_miso};

    always_comb begin
        ctl_word                    = '0;
        ctl_word[B_BUSY]            = busy;
        ctl_word[B_DONE]            = eng_q.done;
        ctl_word[B_CERR]            = eng_q.cerr;
        ctl_word[B_AERR]            = eng_q.aerr;
        ctl_word[B_ATOM]            = eng_q.atom;
        ctl_word[B_PSEL]            = eng_q.psel;
        ctl_word[B_IDX +: MENU_IW]  = eng_q.idx;
        ctl_word[B_LOCK]            = locked;
        ctl_word[B_CNT +: BUF_AW]   = eng_q.cnt;
        ctl_word[B_DS]              = eng_q.ds;
    end
endmodule

// File: rtl/opmenu_spi_seq.sv
module opmenu_spi_seq
    import opmenu_spi_pkg::*;
#(
    parameter int BUF_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lock_set,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [BUF_AW-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_waddr,
    output logic [7:0]        buf_wdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [MENU_IW-1:0] main_idx;
    logic               pfx_sel, locked;
    logic [OP_W-1:0]    main_op, pfx_op;
    logic [31:0]        tbl_rdata, ctl_word;

    opmenu_spi_table u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wr_data(reg_wdata), .lock_set(lock_set), .main_idx(main_idx),
        .pfx_sel(pfx_sel), .main_op(main_op), .pfx_op(pfx_op),
        .locked(locked), .rd_data(tbl_rdata)
    );

    opmenu_spi_engine #(.BUF_AW(BUF_AW)) u_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wr_data(reg_wdata), .locked(locked), .main_op(main_op),
        .pfx_op(pfx_op), .main_idx(main_idx), .pfx_sel(pfx_sel),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .buf_raddr(buf_raddr),
        .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ctl_word(ctl_word)
    );

    assign reg_rdata = (reg_addr == A_CTL) ? ctl_word : tbl_rdata;
endmodule

// File: rtl/opmenu_spi_chk.sv
module opmenu_spi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        bus_req,
    input logic        bus_gnt,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        spi_mosi,
    input logic [31:0] ctl_word,
    input logic        locked
);
    AST_CS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> bus_req); // R9
    AST_FRAME_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(bus_gnt)); // R9
    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n); // R7
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi)); // R7
    AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && reg_wdata[9] && ctl_word[0]) |=> ctl_word[3]); // R8
    AST_UNLOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && reg_wdata[9] && !ctl_word[0] && !locked)
        |=> (ctl_word[4] && !bus_req)); // R6
    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_word[0]) |-> ctl_word[2]); // R4
endmodule

bind opmenu_spi_seq opmenu_spi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .ctl_word(ctl_word), .locked(locked)
);

// File: tb/sim_opmenu_spi_seq.sv
module sim_opmenu_spi_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NBUF = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic lock_set = 1'b0;
    logic bus_req, bus_gnt = 1'b0;
    logic [AW-1:0] buf_raddr, buf_waddr;
    logic [7:0] buf_rdata, buf_wdata;
    logic buf_we, spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opmenu_spi_seq #(.BUF_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_set(lock_set),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .buf_raddr(buf_raddr),
        .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // shared buffer
    logic [7:0] tbmem [NBUF];
    assign buf_rdata = tbmem[buf_raddr];
    initial for (int i = 0; i < NBUF; i++) tbmem[i] = 8'(i * 37 + 11);
    always @(posedge clk) if (buf_we) tbmem[buf_waddr] <= buf_wdata;

    // serial responder
    logic [15:0] lfsr = 16'hACE1;
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        spi_miso = lfsr[0];
    end

    int n_chk = 0, n_err = 0;
    bit ended = 0;

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    typedef struct { bit cs; bit sck; bit mosi; bit we; int widx; } ent_t;
    ent_t tr[$];
    bit m_busy, m_wait, m_act, m_done, m_cerr, m_aerr, m_locked;
    bit m_atom, m_psel, m_ds;
    int m_idx, m_cnt;
    logic [7:0] m_menu [8];
    logic [7:0] m_pfx [2];
    logic [7:0] m_rx;
    bit pb, pl;

    task automatic push_byte(logic [7:0] b, bit wr, int k);
        for (int i = 7; i >= 0; i--) begin
            tr.push_back('{cs: 0, sck: 0, mosi: b[i], we: 0, widx: 0});
            tr.push_back('{cs: 0, sck: 1, mosi: b[i], we: wr && (i == 0), widx: k});
        end
    endtask

    function automatic logic [31:0] exp_rdata(logic [1:0] a);
        logic [31:0] w = '0;
        case (a)
            2'd0: begin
                w[0] = m_busy; w[2] = m_done; w[3] = m_cerr; w[4] = m_aerr;
                w[10] = m_atom; w[11] = m_psel; w[14:12] = 3'(m_idx);
                w[15] = m_locked; w[21:16] = 6'(m_cnt); w[22] = m_ds;
            end
            2'd1: w = {16'h0, m_pfx[1], m_pfx[0]};
            2'd2: w = {m_menu[3], m_menu[2], m_menu[1], m_menu[0]};
            default: w = {m_menu[7], m_menu[6], m_menu[5], m_menu[4]};
        endcase
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            tr.delete();
            {m_busy, m_wait, m_act, m_done, m_cerr, m_aerr, m_locked} = '0;
            {m_atom, m_psel, m_ds} = '0; m_idx = 0; m_cnt = 0;
            for (int i = 0; i < 8; i++) m_menu[i] = 8'h00;
            m_pfx[0] = 8'h00; m_pfx[1] = 8'h00;
        end else begin
            pb = m_busy; pl = m_locked;
            if (reg_we && reg_addr == 2'd0) begin
                if (reg_wdata[2]) m_done = 0;
                if (reg_wdata[3]) m_cerr = 0;
                if (reg_wdata[4]) m_aerr = 0;
            end
            if (m_act) begin
                void'(tr.pop_front());
                if (tr.size() == 0) begin m_act = 0; m_busy = 0; m_done = 1; end
            end else if (m_wait && bus_gnt) begin
                m_wait = 0; m_act = 1;
            end
            if (reg_we && reg_addr == 2'd0) begin
                if (pb) begin
                    if (reg_wdata[9]) m_cerr = 1;
                end else begin
                    m_atom = reg_wdata[10]; m_psel = reg_wdata[11];
                    m_idx = int'(reg_wdata[14:12]); m_cnt = int'(reg_wdata[21:16]);
                    m_ds = reg_wdata[22];
                    if (reg_wdata[9]) begin
                        if (!pl) m_aerr = 1;
                        else begin
                            if (m_atom) begin
                                push_byte(m_pfx[m_psel], 0, 0);
                                tr.push_back('{cs: 1, sck: 0, mosi: 0, we: 0, widx: 0});
                            end
                            push_byte(m_menu[m_idx], 0, 0);
                            if (m_ds) for (int k = 0; k < m_cnt; k++) push_byte(tbmem[k], 1, k);
                            m_busy = 1; m_wait = 1;
                        end
                    end
                end
            end
            if (reg_we && !pl) begin
                if (reg_addr == 2'd1) begin m_pfx[0] = reg_wdata[7:0]; m_pfx[1] = reg_wdata[15:8]; end
                if (reg_addr == 2'd2) for (int i = 0; i < 4; i++) m_menu[i] = reg_wdata[8*i +: 8];
                if (reg_addr == 2'd3) for (int i = 0; i < 4; i++) m_menu[i+4] = reg_wdata[8*i +: 8];
            end
            if (lock_set) m_locked = 1;
        end
    end

    // per-clock comparison and frame monitors
    int low_cnt = 0, falls = 0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            ent_t e;
            e = '{cs: 1, sck: 0, mosi: 0, we: 0, widx: 0};
            if (m_act) e = tr[0];
            if (m_act && e.sck) m_rx = {m_rx[6:0], spi_miso};
            cmp("R2 R7 cs_n", 32'(spi_cs_n), 32'(e.cs));
            cmp("R7 sck", 32'(spi_sck), 32'(e.sck));
            cmp("R1 R2 R7 mosi", 32'(spi_mosi), 32'(e.mosi));
            cmp("R9 bus_req", 32'(bus_req), 32'(m_busy));
            cmp("R7 buf_we", 32'(buf_we), 32'(e.we));
            if (e.we) begin
                cmp("R7 buf_waddr", 32'(buf_waddr), 32'(e.widx));
                cmp("R7 buf_wdata", 32'(buf_wdata), 32'(m_rx));
            end
            cmp("R3 R4 R5 rdata", reg_rdata, exp_rdata(reg_addr));
            if (!spi_cs_n) low_cnt++;
            if (prev_cs && !spi_cs_n) falls++;
            prev_cs = spi_cs_n;
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        cmp(tag, reg_rdata, exp);
    endtask

    task automatic run_cmd(int idx, bit ds, int cnt, bit atom, bit psel, int gdly, bit poke);
        logic [31:0] f;
        int exp_low;
        f = 32'h8000 | (32'(ds) << 22) | (32'(cnt) << 16) | (32'(idx) << 12)
            | (32'(psel) << 11) | (32'(atom) << 10);
        low_cnt = 0; falls = 0;
        wr(2'd0, f | 32'h200);
        if (poke) begin
            wr(2'd0, 32'h0000_2200);
            rd_chk("R8 start while busy", 2'd0, f | 32'h9);
        end
        repeat (gdly) @(posedge clk);
        cmp("R9 no frame before grant", 32'(low_cnt), 0);
        #1 bus_gnt = 1'b1;
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(posedge clk); #1 bus_gnt = 1'b0;
        exp_low = 16 * (1 + (ds ? cnt : 0)) + (atom ? 16 : 0);
        cmp("R7 frame clocks", 32'(low_cnt), 32'(exp_low));
        cmp("R2 frame count", 32'(falls), atom ? 2 : 1);
        rd_chk("R4 done set", 2'd0, f | 32'h4 | (poke ? 32'h8 : 32'h0));
        wr(2'd0, 32'h0000_000C);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_chk("R10 reset ctl", 2'd0, 32'h0);
        rd_chk("R10 reset menu", 2'd3, 32'h0);
        cmp("R10 reset cs_n", 32'(spi_cs_n), 1);
        cmp("R10 reset bus_req", 32'(bus_req), 0);

        wr(2'd2, 32'h03019F05);
        wr(2'd3, 32'hC7AB020B);
        wr(2'd1, 32'h0000_5006);
        wr(2'd0, 32'h0000_1200);
        rd_chk("R6 refused start", 2'd0, 32'h0000_1010);
        cmp("R6 no request", 32'(bus_req), 0);
        wr(2'd0, 32'h0000_0010);
        rd_chk("R4 clear aerr", 2'd0, 32'h0);

        @(posedge clk); #1 lock_set = 1'b1;
        @(posedge clk); #1 lock_set = 1'b0;
        rd_chk("R5 lock flag", 2'd0, 32'h8000);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0000_FFFF);
        rd_chk("R5 menu frozen", 2'd2, 32'h03019F05);
        rd_chk("R5 prefix frozen", 2'd1, 32'h0000_5006);

        run_cmd(1, 0, 0, 0, 0, 0, 0);
        run_cmd(5, 1, 3, 1, 0, 6, 1);
        run_cmd(7, 1, 1, 1, 1, 2, 0);
        run_cmd(0, 1, 0, 0, 0, 1, 0);
        run_cmd(4, 1, 5, 0, 1, 3, 0);
        run_cmd(3, 1, 2, 1, 1, 0, 0);

        repeat (4) @(posedge clk);
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog R9 act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule